// File: doc/BRIEF.md
# Monochrome Host Color Expander

This block turns a one-bit-per-pixel bitmap supplied by a host into a stream of coloured pixels. The host first writes a command word that selects mono expansion, two colour registers and a horizontal bounds register. It then writes a vertical register holding the start row and the row count, and that write arms the operation. From then on the host pushes bitmap words through a data port. Each word is queued in an input FIFO, and the host watches the free-slot count so that it never writes into a full queue.

An internal walker pops one word at a time and scans its 32 bits in pixel order. For each pixel inside the rectangle it emits the coordinate and either the foreground or the background colour. Bits that lie past the row width are skipped. The walker then moves to the next row, and once the final word of the last row has been consumed it drops busy. A write into a full queue is dropped and raises a sticky overflow flag, which the next arming write clears.

Top module: `mono_expander`

## Requirements
- R1: A write to the vertical register (address 4) arms an operation only under all of the following conditions: the block is idle; the command register (address 0) holds 0x9 in bits 3:0 and 2'b10 in bits 27:26; the row count is non-zero; and the right bound is greater than the left bound. Otherwise the write has no effect.
- R2: The horizontal register (address 3) holds the left column in bits 15:0 and the exclusive right column in bits 31:16. The vertical register holds the start row in bits 31:16 and the row count in bits 15:0. Pixels are emitted in row-major order, left to right, with pix_x_o and pix_y_o set to the absolute coordinates.
- R3: Each row takes ceil(width/32) data words. Pixel j of a row comes from word j/32, at bit ((j mod 32)/8)*8 + 7 - (j mod 8). This places byte 0 in bits 7:0 and the MSB of each byte leftmost. Bit positions at or beyond the width produce no pixel.
- R4: A 1 bit yields the foreground register (address 1) and a 0 bit yields the background register (address 2).
- R5: A write to the data port (address 5) while idle is not queued. free_o does not change and no pixel is produced.
- R6: free_o equals DEPTH minus the number of queued words. It is 64 with the defaults and after reset.
- R7: A data-port write while busy and the queue is full is dropped and sets ovf_o. ovf_o stays set until the next arming write clears it.
- R8: busy_o rises in the cycle after an arming write. It falls once the last word of the last row has been consumed. No pixel is valid while busy_o is low.
- R9: After reset: busy_o = 0, ovf_o = 0, pix_valid_o = 0, free_o = DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register or data-port write strobe |
| wr_addr_i | input | 3 | Write target: 0 command, 1 fg, 2 bg, 3 horizontal, 4 vertical, 5 data |
| wr_data_i | input | 32 | Write data |
| free_o | output | $clog2(DEPTH+1) | Free queue slots |
| busy_o | output | 1 | Operation in progress |
| ovf_o | output | 1 | Sticky dropped-write flag |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_x_o | output | CRD_W | Pixel column |
| pix_y_o | output | CRD_W | Pixel row |
| pix_color_o | output | PIX_W | Pixel colour |

## Verification
Some properties hold on every cycle, and the bound checker covers those. free_o never exceeds the depth. An idle data write leaves the free count unchanged. A full-queue write sets the overflow flag, and that flag stays set until a rearm. No pixel appears while idle. Every emitted colour is one of the two colour registers, and consecutive pixels in a row advance by one column. Other behaviour can only be shown by the bench scenarios: the exact bit-to-pixel mapping, the skipping of pad bits, the pixel count per rectangle, the rejection of bad commands and empty rectangles, and the point at which busy falls.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  localparam int WORD_W = 32;
  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_FG   = 3'd1;
  localparam logic [2:0] A_BG   = 3'd2;
  localparam logic [2:0] A_XB   = 3'd3;
  localparam logic [2:0] A_YL   = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;
  localparam logic [3:0] OP_LOAD   = 4'h9;
  localparam logic [1:0] MODE_MONO = 2'b10;
endpackage

// File: rtl/mexp_fifo.sv
module mexp_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = mem[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i && !full_o) wp_q <= wp_q + 1'b1;
      if (pop_i && !empty_o) rp_q <= rp_q + 1'b1;
      case ({push_i && !full_o, pop_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mexp_walker.sv
module mexp_walker #(
  parameter int DW    = 32,
  parameter int CRD_W = 16,
  localparam int BW = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CRD_W-1:0] x0_i,
  input  logic [CRD_W-1:0] width_i,
  input  logic [CRD_W-1:0] y0_i,
  input  logic [CRD_W-1:0] h_i,
  input  logic [DW-1:0]    word_i,
  input  logic             empty_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             pix_valid_o,
  output logic [CRD_W-1:0] pix_x_o,
  output logic [CRD_W-1:0] pix_y_o,
  output logic             pix_bit_o
);
  logic             busy_q, have_q;
  logic [DW-1:0]    word_q;
  logic [BW-1:0]    bit_q;
  logic [CRD_W-1:0] xoff_q, row_q, x0_q, wid_q, y0_q, h_q;
  logic             word_end, row_end, last_row;
  logic [BW-1:0]    bit_idx;

  assign word_end = (bit_q == BW'(DW - 1));
  assign row_end  = ({1'b0, xoff_q} + 1'b1) >= {1'b0, wid_q};
  assign last_row = (row_q == h_q - 1'b1);
  // byte order low-first, bit order MSB-first within a byte
  assign bit_idx  = {bit_q[BW-1:3], ~bit_q[2:0]};

  assign pop_o       = busy_q && !have_q && !empty_i;
  assign busy_o      = busy_q;
  assign pix_valid_o = have_q && (xoff_q < wid_q);
  assign pix_x_o     = x0_q + xoff_q;
  assign pix_y_o     = y0_q + row_q;
  assign pix_bit_o   = word_q[bit_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; have_q <= 1'b0; word_q <= '0; bit_q <= '0;
      xoff_q <= '0; row_q <= '0; x0_q <= '0; wid_q <= '0; y0_q <= '0; h_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1; have_q <= 1'b0; bit_q <= '0; xoff_q <= '0; row_q <= '0;
      x0_q <= x0_i; wid_q <= width_i; y0_q <= y0_i; h_q <= h_i;
    end else if (pop_o) begin
      have_q <= 1'b1; word_q <= word_i; bit_q <= '0;
    end else if (have_q) begin
      bit_q <= bit_q + 1'b1;
      if (word_end) begin
        have_q <= 1'b0;
        if (row_end) begin
          xoff_q <= '0;
          if (last_row) busy_q <= 1'b0;
          else          row_q  <= row_q + 1'b1;
        end else begin
          xoff_q <= xoff_q + 1'b1;
        end
      end else begin
        xoff_q <= xoff_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mono_expander.sv
module mono_expander
  import mexp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PIX_W = 32,
  parameter int CRD_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  output logic [CW-1:0]    free_o,
  output logic             busy_o,
  output logic             ovf_o,
  output logic             pix_valid_o,
  output logic [CRD_W-1:0] pix_x_o,
  output logic [CRD_W-1:0] pix_y_o,
  output logic [PIX_W-1:0] pix_color_o
);
  logic [31:0]       cmd_q, xb_q;
  logic [PIX_W-1:0]  fg_q, bg_q;
  logic              ovf_q;
  logic              cmd_ok, start, push_req, f_full, f_empty, pop, pix_bit;
  logic [WORD_W-1:0] f_word;
  logic [CW-1:0]     f_cnt;
  logic [CRD_W-1:0]  xl, xr;

  assign xl       = xb_q[CRD_W-1:0];
  assign xr       = xb_q[16 +: CRD_W];
  assign cmd_ok   = (cmd_q[3:0] == OP_LOAD) && (cmd_q[27:26] == MODE_MONO);
  assign start    = wr_en_i && (wr_addr_i == A_YL) && cmd_ok && !busy_o
                    && (wr_data_i[15:0] != '0) && (xr > xl);
  assign push_req = wr_en_i && (wr_addr_i == A_DATA) && busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; xb_q <= '0; fg_q <= '0; bg_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          A_CMD:   cmd_q <= wr_data_i;
          A_FG:    fg_q  <= wr_data_i[PIX_W-1:0];
          A_BG:    bg_q  <= wr_data_i[PIX_W-1:0];
          A_XB:    xb_q  <= wr_data_i;
          default: ;
        endcase
      end
      if (start)                  ovf_q <= 1'b0;
      else if (push_req && f_full) ovf_q <= 1'b1;
    end
  end

  mexp_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(start),
    .push_i(push_req), .data_i(wr_data_i), .pop_i(pop),
    .data_o(f_word), .empty_o(f_empty), .full_o(f_full), .cnt_o(f_cnt)
  );

  mexp_walker #(.DW(WORD_W), .CRD_W(CRD_W)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .x0_i(xl), .width_i(xr - xl),
    .y0_i(wr_data_i[16 +: CRD_W]), .h_i(wr_data_i[CRD_W-1:0]),
    .word_i(f_word), .empty_i(f_empty), .pop_o(pop), .busy_o(busy_o),
    .pix_valid_o(pix_valid_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o),
    .pix_bit_o(pix_bit)
  );

  assign free_o      = CW'(DEPTH) - f_cnt;
  assign ovf_o       = ovf_q;
  assign pix_color_o = pix_bit ? fg_q : bg_q;
endmodule

// File: rtl/mexp_checker.sv
module mexp_checker #(
  parameter int DEPTH = 64,
  parameter int PIX_W = 32,
  parameter int CRD_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [CW-1:0]    free_o,
  input logic             busy_o,
  input logic             ovf_o,
  input logic             pix_valid_o,
  input logic [CRD_W-1:0] pix_x_o,
  input logic [CRD_W-1:0] pix_y_o,
  input logic [PIX_W-1:0] pix_color_o,
  input logic [PIX_W-1:0] fg_q,
  input logic [PIX_W-1:0] bg_q
);
  logic dwr, ywr;
  assign dwr = wr_en_i && (wr_addr_i == mexp_pkg::A_DATA);
  assign ywr = wr_en_i && (wr_addr_i == mexp_pkg::A_YL);

  p_free_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o <= CW'(DEPTH));
  p_idle_write_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && dwr) |=> $stable(free_o));
  p_full_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && free_o == '0 && dwr) |=> ovf_o);
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ywr) |=> ovf_o);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pix_valid_o);
  p_color_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_color_o == fg_q || pix_color_o == bg_q));
  p_pix_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && $past(pix_valid_o) && pix_y_o == $past(pix_y_o))
      |-> pix_x_o == $past(pix_x_o) + 1'b1);
endmodule

bind mono_expander mexp_checker #(.DEPTH(DEPTH), .PIX_W(PIX_W), .CRD_W(CRD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .free_o(free_o), .busy_o(busy_o), .ovf_o(ovf_o), .pix_valid_o(pix_valid_o),
  .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .pix_color_o(pix_color_o),
  .fg_q(fg_q), .bg_q(bg_q)
);

// File: tb/sim_mono_expander.sv
`timescale 1ns/1ps
module sim_mono_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  free;
  logic        busy, ovf, pix_valid;
  logic [15:0] pix_x, pix_y;
  logic [31:0] pix_color;

  int checks = 0, fails = 0;
  int cap_n = 0;
  logic [15:0] cap_x [256];
  logic [15:0] cap_y [256];
  logic [31:0] cap_c [256];

  localparam logic [31:0] CMD_OK = 32'h0800_0009;

  typedef struct packed {
    logic [15:0] x0, w, y0, h;
    logic [31:0] fg, bg, seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd5,   16'd8,  16'd3,  16'd2, 32'h00FF_0000, 32'h0000_00FF, 32'h1234_5678},
    '{16'd0,   16'd13, 16'd10, 16'd3, 32'hAAAA_AAAA, 32'h5555_5555, 32'hDEAD_BEEF},
    '{16'd100, 16'd32, 16'd0,  16'd2, 32'h0000_0001, 32'h0000_0000, 32'hF0F0_0F0F},
    '{16'd7,   16'd33, 16'd20, 16'd2, 32'hFFFF_FFFF, 32'h1111_1111, 32'h8001_7FFE},
    '{16'd2,   16'd1,  16'd4,  16'd4, 32'hCAFE_0000, 32'h0000_BABE, 32'hA5A5_A5A5},
    '{16'd50,  16'd40, 16'd9,  16'd1, 32'h0BAD_F00D, 32'h600D_CAFE, 32'h0000_0000}
  };

  mono_expander u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .free_o(free), .busy_o(busy), .ovf_o(ovf),
    .pix_valid_o(pix_valid), .pix_x_o(pix_x), .pix_y_o(pix_y),
    .pix_color_o(pix_color)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (cap_n < 256) begin
        cap_x[cap_n] = pix_x; cap_y[cap_n] = pix_y; cap_c[cap_n] = pix_color;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] gen_word(input logic [31:0] seed, input int r, input int k);
    return seed ^ (32'(r) * 32'h9E37_79B9) ^ (32'(k + 1) * 32'h7F4A_7C15);
  endfunction

  function automatic logic exp_bit(input logic [31:0] seed, input int r, input int j);
    logic [31:0] wd;
    int p;
    wd = gen_word(seed, r, j / 32);
    p  = j % 32;
    return wd[(p / 8) * 8 + 7 - (p % 8)];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 / R6 reset state
    check(!busy && !ovf && !pix_valid, "R9 reset flags", {busy, ovf, pix_valid}, 0);
    check(free == 7'd64, "R6 reset free count", free, 64);

    // table-driven expansion runs
    for (int v = 0; v < 6; v++) begin
      automatic vec_t t = VECS[v];
      automatic int nw = (int'(t.w) + 31) / 32;
      automatic int bad = 0;
      wr(3'd0, CMD_OK);
      wr(3'd1, t.fg);
      wr(3'd2, t.bg);
      wr(3'd3, {t.x0 + t.w, t.x0});
      cap_n = 0;
      wr(3'd4, {t.y0, t.h});
      check(busy == 1'b1, "R8 busy after arm", busy, 1);
      for (int r = 0; r < int'(t.h); r++)
        for (int k = 0; k < nw; k++) begin
          while (free == 0) @(negedge clk);
          wr(3'd5, gen_word(t.seed, r, k));
        end
      wait_idle(5000);
      check(!busy, "R8 busy falls after last word", busy, 0);
      check(cap_n == int'(t.w) * int'(t.h), "R3 pixel count with pad bits skipped",
            cap_n, int'(t.w) * int'(t.h));
      for (int i = 0; i < cap_n && i < 256; i++) begin
        automatic int r = i / int'(t.w);
        automatic int j = i % int'(t.w);
        automatic logic [31:0] ec = exp_bit(t.seed, r, j) ? t.fg : t.bg;
        if (bad == 0 && (cap_x[i] != t.x0 + 16'(j) || cap_y[i] != t.y0 + 16'(r) || cap_c[i] != ec)) begin
          bad = 1;
          $display("FAIL R2/R3/R4 pixel %0d actual=(%0d,%0d,%0h) expected=(%0d,%0d,%0h)",
                   i, cap_x[i], cap_y[i], cap_c[i], t.x0 + 16'(j), t.y0 + 16'(r), ec);
        end
      end
      checks++;
      if (bad != 0) fails++;
    end

    // R1: wrong mode bits do not arm
    wr(3'd0, 32'h0000_0009);
    wr(3'd3, {16'd8, 16'd0});
    wr(3'd4, {16'd0, 16'd1});
    check(!busy, "R1 bad command ignored", busy, 0);
    // R1: zero height does not arm
    wr(3'd0, CMD_OK);
    wr(3'd4, {16'd0, 16'd0});
    check(!busy, "R1 zero height ignored", busy, 0);
    // R1: empty horizontal span does not arm
    wr(3'd3, {16'd4, 16'd4});
    wr(3'd4, {16'd0, 16'd2});
    check(!busy, "R1 empty span ignored", busy, 0);

    // R5: idle data write ignored
    cap_n = 0;
    wr(3'd5, 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    check(free == 7'd64, "R5 idle write not queued", free, 64);
    check(cap_n == 0, "R5 idle write yields no pixel", cap_n, 0);

    // R7: overflow on full queue
    wr(3'd3, {16'd32, 16'd0});
    wr(3'd4, {16'd0, 16'd100});
    for (int i = 0; i < 80; i++) wr(3'd5, 32'h0F0F_0F0F);
    check(ovf == 1'b1, "R7 overflow flagged", ovf, 1);
    for (int i = 0; i < 200 && busy; i++) begin
      wr(3'd5, 32'h0F0F_0F0F);
      repeat (40) @(negedge clk);
    end
    check(!busy, "R8 long run completes", busy, 0);
    check(ovf == 1'b1, "R7 overflow sticky", ovf, 1);
    wr(3'd3, {16'd8, 16'd0});
    wr(3'd4, {16'd0, 16'd1});
    check(ovf == 1'b0, "R7 overflow cleared by arm", ovf, 0);
    check(free == 7'd64, "R6 queue empty after arm", free, 64);
    wr(3'd5, 32'h0000_0081);
    wait_idle(200);
    check(!busy, "R8 one-word run ends", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule